// File: doc/BRIEF.md
# Double-Data-Rate Serial Word Framer

This block turns a stream of parallel converter samples into a two-bits-per-cycle serial stream. The block runs on the fast bit clock and loads one sample word per word period. It presents each word most significant bit first as a pair of bits every cycle: `d_rise` carries the bit for the high half of the bit clock and `d_fall` carries the bit for the low half. A downstream output stage turns each registered pair into true double-data-rate signalling.

A frame marker, also given as a rise/fall pair, runs at the sample rate. It is high for the first half of each word's bit slots and low for the rest, so a receiver can find word boundaries. A two-bit select picks the word length from 8, 10, 12 or 14 bits. The block reads the word and the select in the cycle just before each boundary, so words follow each other with no idle slots.

Top module: `ddrf_framer`

## Requirements
- R1: A word of W bits occupies exactly W/2 clock cycles, so with 8-bit words the bit clock runs at four times the word (sample) rate.
- R2: Each cycle emits two consecutive bits of the current word: `d_rise` is the earlier bit and `d_fall` the next one. Bits go out most significant first, so cycle c carries bits W-1-2c and W-2-2c.
- R3: `len_sel` code k selects W = 8 + 2k (0→8, 1→10, 2→12, 3→14). The word is taken from `word_in[W-1:0]`, and bits of `word_in` at W and above have no effect on the output.
- R4: In cycle c of a word, `fr_rise` is 1 exactly when bit slot 2c < W/2, and `fr_fall` is 1 exactly when slot 2c+1 < W/2. This gives one marker pulse per word, high for the first half of the slots.
- R5: The first cycle of every word shows the word's most significant bit on `d_rise` while both frame bits are 1, and the previous cycle had `fr_rise` = 0 (or was the first cycle after reset).
- R6: `word_in` and `len_sel` are sampled only at the clock edge that ends the last cycle of a word, or at the first edge after reset. Changes at any other time do not alter the output.
- R7: Words follow each other without gaps. The cycle after the last cycle of a word is the first cycle of the next word.
- R8: While `rst_n` is sampled low, every output is 0 after the edge. The first edge after release loads a new word, and framing restarts at a word boundary.
- R9: `bclk_en` is 0 in reset. It is 1 from the first emitted bit pair onward and stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock, one cycle per bit pair |
| rst_n | input | 1 | Synchronous active-low reset |
| word_in | input | MAX_W (14) | Parallel sample word, right-aligned |
| len_sel | input | SEL_W (2) | Word length code, W = 8 + 2·code |
| d_rise | output | 1 | Bit for the high half of the bit clock |
| d_fall | output | 1 | Bit for the low half of the bit clock |
| fr_rise | output | 1 | Frame marker, high half |
| fr_fall | output | 1 | Frame marker, low half |
| bclk_en | output | 1 | Bit clock / data valid enable |

## Verification
Two things can fall in the same cycle. The edge that ends a word both loads the next word and applies a new length, while the last bit pair of the old word was set by the previous length. The bench changes `len_sel` at every word boundary and also scrambles it, together with `word_in`, in the middle of each word. It then judges every bit pair and every frame bit against the length latched at the boundary. A reset is also made to coincide with a boundary load and with a mid-word cycle, and the bench checks that the zeroed outputs and the restarted framing meet R8.

// File: rtl/ddrf_pkg.sv
package ddrf_pkg;

    // Word length for a select code, clamped to the widest supported word.
    function automatic int word_len(input int code, input int min_w, input int max_w);
        int w;
        w = min_w + 2 * code;
        return (w > max_w) ? max_w : w;
    endfunction

endpackage

// File: rtl/ddrf_len_dec.sv
module ddrf_len_dec #(
    parameter int MIN_W = 8,
    parameter int MAX_W = 14,
    parameter int SEL_W = 2,
    parameter int WL_W  = 4,
    parameter int CNT_W = 3
) (
    input  logic [SEL_W-1:0] sel,
    output logic [WL_W-1:0]  wlen,
    output logic [CNT_W-1:0] last,
    output logic [WL_W-1:0]  shamt
);
    int w_i;

    assign w_i   = ddrf_pkg::word_len(int'(sel), MIN_W, MAX_W);
    assign wlen  = WL_W'(w_i);
    assign last  = CNT_W'(w_i / 2 - 1);
    assign shamt = WL_W'(MAX_W - w_i);
endmodule

// File: rtl/ddrf_align.sv
module ddrf_align #(
    parameter int MAX_W = 14,
    parameter int WL_W  = 4
) (
    input  logic [MAX_W-1:0] word,
    input  logic [WL_W-1:0]  shamt,
    output logic [MAX_W-1:0] msbj
);
    // Left-justify: bits above the word length fall off the top.
    assign msbj = word << shamt;
endmodule

// File: rtl/ddrf_frame_gen.sv
module ddrf_frame_gen #(
    parameter int CNT_W = 3,
    parameter int WL_W  = 4
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [WL_W-1:0]  wlen,
    output logic [1:0]       fr
);
    // fr[0]: high half (slot 2c), fr[1]: low half (slot 2c+1)
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign fr[h] = (4 * int'(cnt) + 2 * h) < int'(wlen);
    end
endmodule

// File: rtl/ddrf_framer.sv
module ddrf_framer #(
    parameter int MIN_W = 8,
    parameter int MAX_W = 14,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAX_W-1:0] word_in,
    input  logic [SEL_W-1:0] len_sel,
    output logic             d_rise,
    output logic             d_fall,
    output logic             fr_rise,
    output logic             fr_fall,
    output logic             bclk_en
);
    localparam int WL_W  = $clog2(MAX_W + 1);
    localparam int CNT_W = $clog2(MAX_W / 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] last;
        logic [WL_W-1:0]  wlen;
        logic [MAX_W-1:0] sh;
        logic             d_rise;
        logic             d_fall;
        logic             fr_rise;
        logic             fr_fall;
        logic             en;
    } st_t;

    st_t st_d, st_q;

    logic [WL_W-1:0]  dec_wlen, dec_shamt, wlen_nx;
    logic [CNT_W-1:0] dec_last, cnt_nx;
    logic [MAX_W-1:0] msbj;
    logic [1:0]       fr_nx;
    logic             load;

    ddrf_len_dec #(
        .MIN_W(MIN_W), .MAX_W(MAX_W), .SEL_W(SEL_W), .WL_W(WL_W), .CNT_W(CNT_W)
    ) u_dec (
        .sel  (len_sel),
        .wlen (dec_wlen),
        .last (dec_last),
        .shamt(dec_shamt)
    );

    ddrf_align #(.MAX_W(MAX_W), .WL_W(WL_W)) u_align (
        .word (word_in),
        .shamt(dec_shamt),
        .msbj (msbj)
    );

    // Boundary: first edge after reset or end of the current word.
    always_comb begin
        load    = !st_q.en || (st_q.cnt == st_q.last);
        cnt_nx  = load ? '0 : st_q.cnt + CNT_W'(1);
        wlen_nx = load ? dec_wlen : st_q.wlen;
    end

    ddrf_frame_gen #(.CNT_W(CNT_W), .WL_W(WL_W)) u_frame (
        .cnt (cnt_nx),
        .wlen(wlen_nx),
        .fr  (fr_nx)
    );

    always_comb begin
        st_d         = st_q;
        st_d.cnt     = cnt_nx;
        st_d.wlen    = wlen_nx;
        st_d.en      = 1'b1;
        st_d.fr_rise = fr_nx[0];
        st_d.fr_fall = fr_nx[1];
        if (load) begin
            st_d.last   = dec_last;
            st_d.d_rise = msbj[MAX_W-1];
            st_d.d_fall = msbj[MAX_W-2];
            st_d.sh     = msbj << 2;
        end else begin
            st_d.d_rise = st_q.sh[MAX_W-1];
            st_d.d_fall = st_q.sh[MAX_W-2];
            st_d.sh     = st_q.sh << 2;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign d_rise  = st_q.d_rise;
    assign d_fall  = st_q.d_fall;
    assign fr_rise = st_q.fr_rise;
    assign fr_fall = st_q.fr_fall;
    assign bclk_en = st_q.en;
endmodule

// File: rtl/ddrf_framer_chk.sv
module ddrf_framer_chk #(
    parameter int MIN_W = 8,
    parameter int MAX_W = 14
) (
    input logic clk,
    input logic rst_n,
    input logic d_rise,
    input logic d_fall,
    input logic fr_rise,
    input logic fr_fall,
    input logic bclk_en
);
    logic       prev_fr;
    logic       seen;
    logic [3:0] gap;
    logic       start;

    assign start = fr_rise && !prev_fr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_fr <= 1'b0;
            seen    <= 1'b0;
            gap     <= '0;
        end else begin
            prev_fr <= fr_rise;
            if (start) begin
                seen <= 1'b1;
                gap  <= 4'd1;
            end else if (gap != 4'hF) begin
                gap <= gap + 4'd1;
            end
        end
    end

    // R1: distance between frame starts is a legal word period
    p_word_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && seen) |-> (int'(gap) >= MIN_W / 2 && int'(gap) <= MAX_W / 2));

    // R4: the marker never goes low in the high half and back high in the low half
    p_frame_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fr_fall |-> fr_rise);

    // R5: a word start shows a full-high marker pair while enabled
    p_start_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (fr_fall && bclk_en));

    // R8: reset clears every output
    p_rst_quiet_r8: assert property (@(posedge clk)
        !rst_n |=> !(d_rise || d_fall || fr_rise || fr_fall || bclk_en));

    // R9: enable stays high once set
    p_en_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_en |=> bclk_en);
endmodule

bind ddrf_framer ddrf_framer_chk #(.MIN_W(MIN_W), .MAX_W(MAX_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_rise (d_rise),
    .d_fall (d_fall),
    .fr_rise(fr_rise),
    .fr_fall(fr_fall),
    .bclk_en(bclk_en)
);

// File: tb/sim_ddrf_framer.sv
`timescale 1ns/1ps
module sim_ddrf_framer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [13:0] word_in;
    logic [1:0]  len_sel;
    logic        d_rise, d_fall, fr_rise, fr_fall, bclk_en;
    int          n_chk = 0;
    int          n_err = 0;

    always #4 clk = ~clk;

    ddrf_framer u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_in(word_in),
        .len_sel(len_sel),
        .d_rise (d_rise),
        .d_fall (d_fall),
        .fr_rise(fr_rise),
        .fr_fall(fr_fall),
        .bclk_en(bclk_en)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_quiet(input string tag);
        chk({"R8 ", tag}, "d_rise", int'(d_rise), 0);
        chk({"R8 ", tag}, "d_fall", int'(d_fall), 0);
        chk({"R8 ", tag}, "fr_rise", int'(fr_rise), 0);
        chk({"R8 ", tag}, "fr_fall", int'(fr_fall), 0);
        chk({"R9 ", tag}, "bclk_en", int'(bclk_en), 0);
    endtask

    // Called just after a negedge, before the loading edge.
    task automatic run_word(input logic [13:0] w, input int s, input int abort_at);
        int wl = 8 + 2 * s;
        int hc = wl / 2;
        word_in = w;
        len_sel = 2'(s);
        for (int c = 0; c < hc; c++) begin
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R2 R3 R6 W=%0d c=%0d", wl, c), "d_rise", int'(d_rise), int'(w[wl-1-2*c]));
            chk($sformatf("R2 R3 R6 W=%0d c=%0d", wl, c), "d_fall", int'(d_fall), int'(w[wl-2-2*c]));
            chk($sformatf("R4 W=%0d c=%0d", wl, c), "fr_rise", int'(fr_rise), int'(4*c < wl));
            chk($sformatf("R4 W=%0d c=%0d", wl, c), "fr_fall", int'(fr_fall), int'(4*c + 2 < wl));
            chk("R9", "bclk_en", int'(bclk_en), 1);
            if (c == 0) begin
                chk("R5 R7 start", "fr_rise&fr_fall", int'(fr_rise & fr_fall), 1);
                // scramble inputs mid-word: must be ignored (R6)
                word_in = ~w;
                len_sel = ~2'(s);
            end
            if (c == hc - 1) chk("R1 word end", "fr_rise", int'(fr_rise), 0);
            if (c == abort_at) return;
        end
    endtask

    task automatic do_reset(input string tag);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_quiet(tag);
        @(posedge clk);
        @(negedge clk);
        chk_quiet(tag);
        rst_n = 1'b1;
    endtask

    task automatic finish_up;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(64'd8 * 64'd200000);
        n_err++;
        $display("FAIL watchdog: actual running expected done");
        finish_up();
    end

    initial begin
        rst_n   = 1'b0;
        word_in = '0;
        len_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_quiet("initial");
        rst_n = 1'b1;

        // R1/R3: every 8-bit value, with junk above bit 7
        for (int v = 0; v < 256; v++)
            run_word({6'(v * 7 + 21), 8'(v)}, 0, -1);

        // wider words, fixed length per sweep
        for (int s = 1; s < 4; s++)
            for (int k = 0; k < 64; k++)
                run_word(14'(k * 263) ^ 14'(k << 5) ^ 14'h1555, s, -1);

        // length changes at every boundary (R6, R7)
        for (int k = 0; k < 40; k++)
            run_word(14'(k * 517 + 3), k % 4, -1);

        // R8: reset in the middle of a word
        run_word(14'h3FFF, 3, 2);
        do_reset("mid-word");
        run_word(14'h02AB, 1, -1);
        run_word(14'h2001, 3, -1);

        // R8: reset landing on the boundary load edge
        run_word(14'h1234, 2, 5);
        do_reset("boundary");
        run_word(14'h00A5, 0, -1);
        run_word(14'h3C3C, 2, -1);
        run_word(14'h0000, 1, -1);

        finish_up();
    end
endmodule